// File: doc/BRIEF.md
# Trim Programming Sequencer

This block is the host-side controller that trims a serially programmed capacitor array with non-volatile storage. A start pulse latches an 11-bit desired control word. The controller then drives three lines: serial data, serial clock and the program strobe. It reads back every stored bit through a digital readback input and compares the readback with the bitwise inverse of the desired word, because stored selection is active low. It writes only the bits that differ, one per strobe cycle. Finally it reads the whole word back again to verify it.

An optional erase-first input adds an erase cycle before the first readback. In that cycle the controller shifts an all-ones frame and applies one strobe. After a run the controller reports completion, how many bits it wrote, and whether verification failed. The serial clock divider, the strobe width, the idle gap and the readback settle time are all parameters in system clock cycles.

Top module: `trim_prog_seq`

## Requirements
- R1: After reset, ser_clk, ser_data, prog_strobe, busy, done and verify_fail are 0 and write_count is 0.
- R2: Every frame has exactly 11 rising edges of ser_clk and presents bit 0 first. Each low half of ser_clk lasts HALF_DIV system cycles. ser_data never changes on the cycle in which ser_clk rises.
- R3: To read position i, the controller shifts a frame in which only bit i is 0. It then holds ser_data and ser_clk high for SETTLE_CYC cycles and samples rb_bit in the last of those cycles. Positions are read in ascending order.
- R4: The target stored pattern is the bitwise inverse of desired. After done rises, write_count equals the number of positions where the first readback differs from that target.
- R5: The controller runs one write cycle for each differing position, in ascending order, and for no other position. A write cycle shifts a frame in which only the target bit is 0 and then raises prog_strobe.
- R6: prog_strobe stays high for exactly STROBE_CYC cycles, with ser_clk held high during that time. At least IDLE_CYC cycles pass after it falls before the next frame begins.
- R7: When erase_first is 1 at start, the controller first shifts an all-ones frame and applies one strobe, and only then begins the initial readback.
- R8: After the writes, the controller reads all 11 positions again. verify_fail is set if any of them differs from the target, and no further strobe follows.
- R9: busy is high from the cycle after an accepted start until the run ends. done then rises and stays high until the next accepted start.
- R10: A start pulse while busy, including any change of desired or erase_first at that time, has no effect on the run in progress.
- R11: Starting from an all-ones store, a desired word with only bit 2 and bit 4 set produces exactly two writes: bit 2 first, then bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin a run |
| erase_first | input | 1 | Request an erase cycle before the initial readback |
| desired | input | 11 | Desired control word, latched at start |
| rb_bit | input | 1 | Digital readback of the selected stored bit |
| ser_clk | output | 1 | Serial clock to the trim device |
| ser_data | output | 1 | Serial data to the trim device |
| prog_strobe | output | 1 | Program strobe enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| write_count | output | 4 | Number of bits written in the last run |
| verify_fail | output | 1 | Final readback mismatched the target |

## Verification
The hardest situation to reach from the ports is a verification failure. Writes only clear stored bits, so the failure appears when a stored 0 must become 1. The bench's device model clears a bit on each single-bit strobe. A run is started against a store left by an earlier run whose target needs a cleared bit raised again. The writes are then attempted, but the final readback cannot match. A second start is also pulsed mid-run with a different word and erase request, and the observed write sequence must still match the first request.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;

    parameter int unsigned TRIM_BITS = 11;
    parameter int unsigned IDX_W     = $clog2(TRIM_BITS + 1);

    typedef logic [TRIM_BITS-1:0] trim_word_t;
    typedef logic [IDX_W-1:0]     trim_idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_STROBE,
        ST_GAP,
        ST_HOLD,
        ST_COMPARE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_ERASE,
        PH_READ,
        PH_WRITE,
        PH_VERIFY
    } seq_phase_e;

    // Frame that selects a single position: all ones except bit pos.
    function automatic trim_word_t sel_frame(trim_idx_t pos);
        trim_word_t w;
        w = '1;
        for (int i = 0; i < TRIM_BITS; i++)
            if (trim_idx_t'(i) == pos) w[i] = 1'b0;
        return w;
    endfunction

    function automatic trim_idx_t count_ones(trim_word_t w);
        trim_idx_t n;
        n = '0;
        for (int i = 0; i < TRIM_BITS; i++)
            n = n + trim_idx_t'(w[i]);
        return n;
    endfunction

    // Lowest set position at or above from; TRIM_BITS when none.
    function automatic trim_idx_t first_from(trim_word_t m, trim_idx_t from);
        trim_idx_t r;
        r = trim_idx_t'(TRIM_BITS);
        for (int i = TRIM_BITS - 1; i >= 0; i--)
            if (m[i] && (trim_idx_t'(i) >= from)) r = trim_idx_t'(i);
        return r;
    endfunction

endpackage

// File: rtl/trim_wait_timer.sv
module trim_wait_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= value;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R6
    timer_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/trim_frame_tx.sv
module trim_frame_tx
    import trim_prog_pkg::*;
#(
    parameter int unsigned HALF_DIV = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  trim_word_t word,
    output logic       sclk,
    output logic       sdat,
    output logic       done
);

    localparam int unsigned CW   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam trim_idx_t   LAST = trim_idx_t'(TRIM_BITS - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    trim_idx_t     pos_q;
    trim_word_t    sh_q;
    logic          sclk_q, sdat_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            pos_q    <= '0;
            sh_q     <= '0;
            sclk_q   <= 1'b0;
            sdat_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                active_q <= 1'b1;
                sh_q     <= word;
                pos_q    <= '0;
                cnt_q    <= '0;
                sclk_q   <= 1'b0;
                sdat_q   <= word[0];
            end else if (active_q) begin
                if (cnt_q == CW'(HALF_DIV - 1)) begin
                    cnt_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else if (pos_q == LAST) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        pos_q  <= pos_q + 1'b1;
                        sdat_q <= sh_q[pos_q + 1'b1];
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign sdat = sdat_q;
    assign done = done_q;

    // R2
    data_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_q) |-> $stable(sdat_q));

endmodule

// File: rtl/trim_prog_seq.sv
module trim_prog_seq
    import trim_prog_pkg::*;
#(
    parameter int unsigned HALF_DIV   = 10,
    parameter int unsigned STROBE_CYC = 1000000,
    parameter int unsigned IDLE_CYC   = 400,
    parameter int unsigned SETTLE_CYC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 erase_first,
    input  logic [TRIM_BITS-1:0] desired,
    input  logic                 rb_bit,
    output logic                 ser_clk,
    output logic                 ser_data,
    output logic                 prog_strobe,
    output logic                 busy,
    output logic                 done,
    output logic [IDX_W-1:0]     write_count,
    output logic                 verify_fail
);

    localparam int unsigned MAX_A = (STROBE_CYC > IDLE_CYC) ? STROBE_CYC : IDLE_CYC;
    localparam int unsigned MAX_C = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
    localparam int unsigned TW    = $clog2(MAX_C + 1);
    localparam trim_idx_t   LAST  = trim_idx_t'(TRIM_BITS - 1);
    localparam trim_idx_t   NONE  = trim_idx_t'(TRIM_BITS);

    seq_state_e st_q;
    seq_phase_e ph_q;
    trim_idx_t  idx_q, cnt_q;
    trim_word_t target_q, rb_q, diff_q;
    logic       done_q, fail_q;

    logic          tx_load, tx_done, tx_sclk, tx_sdat;
    trim_word_t    tx_word, rb_next, cmp_diff;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    trim_idx_t     nxt_wr, first_diff;

    assign cmp_diff   = rb_q ^ target_q;
    assign first_diff = first_from(cmp_diff, '0);
    assign nxt_wr     = first_from(diff_q, idx_q + 1'b1);

    always_comb begin
        rb_next = rb_q;
        for (int i = 0; i < TRIM_BITS; i++)
            if (trim_idx_t'(i) == idx_q) rb_next[i] = rb_bit;
    end

    always_comb begin
        tx_load  = 1'b0;
        tx_word  = '1;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            ST_IDLE: if (start) begin
                tx_load = 1'b1;
                tx_word = erase_first ? '1 : sel_frame('0);
            end
            ST_FRAME: if (tx_done) begin
                tmr_load = 1'b1;
                tmr_val  = (ph_q == PH_ERASE || ph_q == PH_WRITE) ?
                           TW'(STROBE_CYC - 1) : TW'(SETTLE_CYC - 1);
            end
            ST_STROBE: if (tmr_zero) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(IDLE_CYC - 1);
            end
            ST_GAP: if (tmr_zero) begin
                tx_load = 1'b1;
                tx_word = (ph_q == PH_WRITE && nxt_wr != NONE) ?
                          sel_frame(nxt_wr) : sel_frame('0);
            end
            ST_HOLD: if (tmr_zero && idx_q != LAST) begin
                tx_load = 1'b1;
                tx_word = sel_frame(idx_q + 1'b1);
            end
            ST_COMPARE: begin
                tx_load = 1'b1;
                tx_word = (cmp_diff != '0) ? sel_frame(first_diff) : sel_frame('0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ph_q     <= PH_READ;
            idx_q    <= '0;
            cnt_q    <= '0;
            target_q <= '0;
            rb_q     <= '0;
            diff_q   <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    target_q <= ~desired;
                    done_q   <= 1'b0;
                    fail_q   <= 1'b0;
                    cnt_q    <= '0;
                    idx_q    <= '0;
                    ph_q     <= erase_first ? PH_ERASE : PH_READ;
                    st_q     <= ST_FRAME;
                end
                ST_FRAME: if (tx_done)
                    st_q <= (ph_q == PH_ERASE || ph_q == PH_WRITE) ? ST_STROBE : ST_HOLD;
                ST_STROBE: if (tmr_zero)
                    st_q <= ST_GAP;
                ST_GAP: if (tmr_zero) begin
                    st_q <= ST_FRAME;
                    if (ph_q == PH_ERASE) begin
                        ph_q  <= PH_READ;
                        idx_q <= '0;
                    end else if (nxt_wr != NONE) begin
                        idx_q <= nxt_wr;
                    end else begin
                        ph_q  <= PH_VERIFY;
                        idx_q <= '0;
                    end
                end
                ST_HOLD: if (tmr_zero) begin
                    rb_q <= rb_next;
                    if (idx_q != LAST) begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= ST_FRAME;
                    end else if (ph_q == PH_READ) begin
                        st_q <= ST_COMPARE;
                    end else begin
                        fail_q <= (rb_next != target_q);
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                ST_COMPARE: begin
                    diff_q <= cmp_diff;
                    cnt_q  <= count_ones(cmp_diff);
                    st_q   <= ST_FRAME;
                    if (cmp_diff != '0) begin
                        ph_q  <= PH_WRITE;
                        idx_q <= first_diff;
                    end else begin
                        ph_q  <= PH_VERIFY;
                        idx_q <= '0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    trim_frame_tx #(.HALF_DIV(HALF_DIV)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .load (tx_load),
        .word (tx_word),
        .sclk (tx_sclk),
        .sdat (tx_sdat),
        .done (tx_done)
    );

    trim_wait_timer #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .load  (tmr_load),
        .value (tmr_val),
        .zero  (tmr_zero)
    );

    assign busy        = (st_q != ST_IDLE);
    assign ser_clk     = busy ? tx_sclk : 1'b0;
    assign ser_data    = (st_q == ST_HOLD) ? 1'b1 : (busy ? tx_sdat : 1'b0);
    assign prog_strobe = (st_q == ST_STROBE);
    assign done        = done_q;
    assign write_count = cnt_q;
    assign verify_fail = fail_q;

    logic [31:0] strb_run;
    always_ff @(posedge clk) begin
        if (rst)              strb_run <= '0;
        else if (prog_strobe) strb_run <= strb_run + 1'b1;
        else                  strb_run <= '0;
    end

    // R6
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_strobe) |-> (strb_run == STROBE_CYC));

    // R6
    clk_high_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        prog_strobe |-> ser_clk);

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    fail_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        verify_fail |-> done);

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(target_q));

endmodule

// File: tb/trim_prog_seq_tb.sv
`timescale 1ns/1ps
module trim_prog_seq_tb;

    localparam int HALF   = 2;
    localparam int STROBE = 20;
    localparam int IDLE   = 5;
    localparam int SETTLE = 3;
    localparam int NB     = 11;
    localparam int ERASE_TAG = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic erase_first = 1'b0;
    logic [NB-1:0] desired = '0;
    logic rb_bit;
    logic ser_clk, ser_data, prog_strobe, busy, done, verify_fail;
    logic [3:0] write_count;

    always #2.5 clk = ~clk;

    trim_prog_seq #(.HALF_DIV(HALF), .STROBE_CYC(STROBE), .IDLE_CYC(IDLE),
                    .SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .erase_first(erase_first),
        .desired(desired), .rb_bit(rb_bit), .ser_clk(ser_clk),
        .ser_data(ser_data), .prog_strobe(prog_strobe), .busy(busy),
        .done(done), .write_count(write_count), .verify_fail(verify_fail));

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int zero_pos(logic [NB-1:0] w);
        for (int i = 0; i < NB; i++) if (!w[i]) return i;
        return ERASE_TAG;
    endfunction

    // Device model: shift on rising serial clock, program on rising strobe.
    logic [NB-1:0] sr = '1;
    logic [NB-1:0] stored = '1;
    logic prev_sclk = 0, prev_strb = 0, prev_sdat = 0;
    int low_run = 0, strb_run = 0, gap_run = 0;
    bit in_gap = 0;
    int exp_q[$];
    int got_q[$];

    always_comb begin
        int zp;
        zp = zero_pos(sr);
        rb_bit = (ser_clk && ser_data && zp < NB) ? stored[zp] : 1'b0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (ser_clk && !prev_sclk) begin
                sr <= {ser_data, sr[NB-1:1]};
                // R2: data stable at rising edge, low half length
                if (ser_data != prev_sdat) chk(0, "R2 data at rise", ser_data, prev_sdat);
                if (low_run != HALF) chk(0, "R2 low half", low_run, HALF);
            end
            low_run = (busy && !ser_clk) ? low_run + 1 : 0;

            if (prog_strobe && !prev_strb) begin
                int zp;
                zp = zero_pos(sr);
                got_q.push_back(zp);
                if (zp == ERASE_TAG) stored <= '1;
                else stored[zp] <= 1'b0;
                // R5: scoreboard order of writes
                if (exp_q.size() == 0) chk(0, "R5 unexpected strobe", zp, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(zp == e, "R5 write position", zp, e);
                end
                // R6: clock held high with strobe
                chk(ser_clk == 1'b1, "R6 clock high in strobe", ser_clk, 1);
            end
            if (prog_strobe) strb_run++;
            if (!prog_strobe && prev_strb) begin
                chk(strb_run == STROBE, "R6 strobe width", strb_run, STROBE);
                strb_run = 0;
                in_gap = 1;
                gap_run = 0;
            end
            if (in_gap) begin
                if ((!ser_clk && prev_sclk) || !busy) begin
                    chk(gap_run >= IDLE, "R6 idle gap", gap_run, IDLE);
                    in_gap = 0;
                end else gap_run++;
            end
        end
        prev_sclk = ser_clk;
        prev_strb = prog_strobe;
        prev_sdat = ser_data;
    end

    task automatic run_case(input logic [NB-1:0] want, input bit erase,
                            input bit poke, input string req);
        logic [NB-1:0] s, target, diff, fin;
        int cnt;
        s      = erase ? '1 : stored;
        target = ~want;
        diff   = s ^ target;
        fin    = s & ~diff;
        cnt    = 0;
        got_q.delete();
        if (erase) exp_q.push_back(ERASE_TAG);
        for (int i = 0; i < NB; i++)
            if (diff[i]) begin exp_q.push_back(i); cnt++; end
        @(negedge clk);
        desired = want; erase_first = erase; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {req, " R9 busy after start"}, busy, 1);
        chk(done == 1'b0, {req, " R9 done cleared"}, done, 0);
        if (poke) begin
            repeat (100) @(negedge clk);
            desired = ~want; erase_first = ~erase; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(write_count == cnt, {req, " R4 write count"}, write_count, cnt);
        chk(verify_fail == (fin != target), {req, " R8 verify flag"}, verify_fail, fin != target);
        chk(stored == fin, {req, " R5 store contents"}, stored, fin);
        chk(exp_q.size() == 0, {req, " R5 missing writes"}, exp_q.size(), 0);
        chk(busy == 1'b0, {req, " R9 idle at end"}, busy, 0);
        exp_q.delete();
        repeat (10) @(negedge clk);
        chk(done == 1'b1, {req, " R9 done held"}, done, 1);
        chk(prog_strobe == 1'b0, {req, " R8 no retry"}, prog_strobe, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(ser_clk == 0, "R1 ser_clk", ser_clk, 0);
        chk(ser_data == 0, "R1 ser_data", ser_data, 0);
        chk(prog_strobe == 0, "R1 strobe", prog_strobe, 0);
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk(write_count == 0 && verify_fail == 0, "R1 count/fail", write_count, 0);

        // R11: bit2 and bit4 from an erased store
        run_case(11'h014, 1'b0, 1'b0, "R11 example");
        chk(got_q.size() == 2, "R11 write total", got_q.size(), 2);
        if (got_q.size() == 2) begin
            chk(got_q[0] == 2, "R11 first write", got_q[0], 2);
            chk(got_q[1] == 4, "R11 second write", got_q[1], 4);
        end

        // R3/R4: same word again needs no writes
        run_case(11'h014, 1'b0, 1'b0, "R3 reread");
        chk(got_q.size() == 0, "R4 no redundant writes", got_q.size(), 0);

        // R7: erase first, then several writes
        run_case(11'h2A5, 1'b1, 1'b0, "R7 erase");
        chk(got_q.size() > 0 && got_q[0] == ERASE_TAG, "R7 erase first",
            got_q.size() > 0 ? got_q[0] : -1, ERASE_TAG);

        // R8: target needs cleared bits raised -> verify fails
        run_case(11'h014, 1'b0, 1'b0, "R8 fail");
        chk(verify_fail == 1'b1, "R8 fail expected", verify_fail, 1);

        // R10: start while busy ignored
        run_case(11'h7FF, 1'b1, 1'b1, "R10 poke");
        run_case(11'h401, 1'b0, 1'b1, "R10 poke2");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule